// File: doc/BRIEF.md
# Two-Wire Register Port for a Converter Peripheral

This block is the serial-bus slave of a small analog converter peripheral. It oversamples the bus clock and data lines with the system clock, recognises bus conditions, and answers to one 7-bit address. That address is chosen by two strap inputs that can each be low, high or floating. Behind the address sit two registers: a 16-bit conversion result that is read-only, and an 8-bit configuration byte that the bus master can write. The block never drives the clock line. It pulls the data line low only to acknowledge a byte or to send a zero data bit. Open-drain behaviour is modelled by an output that, when high, pulls the line low.

A read returns a fixed burst of three bytes: result high, result low, then the configuration byte with the converter's freshness flag in the top bit. Any byte past the third reads as all ones. A write stores exactly one byte. The slave also answers the broadcast address with two commands. One samples the straps again. The other samples the straps again and also returns the registers to their power-up values. The block recognises the high-speed master code, records the mode, and does not acknowledge that code.

Top module: `i2c_reg_port`

## Requirements
- R1: The straps are coded 00 = low, 01 = high, 10 or 11 = floating (first strap listed first). The own address is low/low 48h, low/float 49h, low/high 4Ah, high/low 4Ch, high/float 4Dh, high/high 4Eh, float/low 4Bh and float/high 4Fh. With float/float no address is acknowledged.
- R2: The straps are sampled only while reset is asserted and on a qualifying broadcast command. A strap change at any other time leaves the address unchanged.
- R3: The broadcast address 00h (write) is acknowledged. A following byte 04h is acknowledged and samples the straps again without touching the registers. A following byte 06h is acknowledged, samples the straps, returns the configuration to its default and gives a one-cycle `swResetStb`. The broadcast address with the read bit set is not acknowledged.
- R4: An address byte matching 00001xxx is not acknowledged and sets `hsMode`. `hsMode` clears at the next STOP.
- R5: A read returns result[15:8], then result[7:0], then {staleFlag, cfg[6:0]}, then FFh for every later byte. The low byte comes from the result captured when the high byte was loaded. The master may end the read after any byte.
- R6: A write acknowledges and stores the first data byte into the configuration register. Later data bytes in the same transfer are neither acknowledged nor stored.
- R7: `sdaPullLow` changes only while the synchronised clock is low, and is released after START and STOP.
- R8: START (data falls while clock is high) begins address reception from any state, so a repeated START restarts the address phase. STOP (data rises while clock is high) returns the block to idle.
- R9: After a master NACK on a read byte, the slave releases data and waits for START or STOP. After an address mismatch, the slave drives nothing until the next START.
- R10: `cfgReadPulse` is high for exactly one cycle each time the configuration byte is loaded for transmission.
- R11: After reset the configuration is 8Ch, `hsMode` is 0 and `sdaPullLow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | When 1, the data line is pulled low |
| strapA | input | 2 | First address strap: 00 low, 01 high, 1x floating |
| strapB | input | 2 | Second address strap, same coding |
| resultIn | input | 16 | Current conversion result from the converter |
| staleFlag | input | 1 | Freshness flag returned in bit 7 of the configuration byte |
| cfgOut | output | 8 | Configuration register |
| cfgReadPulse | output | 1 | One-cycle pulse when the configuration byte is loaded for a read |
| swResetStb | output | 1 | One-cycle pulse on the broadcast reset command |
| hsMode | output | 1 | High-speed mode flag |

## Verification
A controller stuck in the wrong phase shows at the ports within one byte. The acknowledge bit appears where none is due, or is missing, so the master sees the wrong ACK on the ninth clock of that byte. A bad read index or a stale capture register shows up as a wrong byte value on the next read burst. A wrong strap latch shows up on the very next address byte, which is acknowledged at the wrong address. Data-line changes while the clock is high would be seen by the other devices as false START or STOP conditions, so the bench counts them at every cycle.

// File: rtl/i2c_reg_port_pkg.sv
package i2c_reg_port_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_RXDATA, ST_ACKDRV, ST_ACKEND,
    ST_TX, ST_MACK, ST_MNEXT, ST_IGNORE
  } ctrlState_e;

  typedef enum logic [1:0] {K_WRITE, K_READ, K_GC, K_DONE} xferKind_e;

  typedef struct packed {
    logic       shiftIn;
    logic       loadTx;
    logic [1:0] rdSel;
    logic       cfgWrite;
    logic       gcLatch;
    logic       gcReset;
  } dpStrobe_t;

  // strap level: 0 low, 1 high, 2 floating
  function automatic logic [1:0] strapLevel(input logic [1:0] code);
    return code[1] ? 2'd2 : (code[0] ? 2'd1 : 2'd0);
  endfunction

  // returns {valid, address}
  function automatic logic [ADDR_W:0] strapDecode(input logic [1:0] a, input logic [1:0] b);
    logic [ADDR_W:0] r;
    case ({strapLevel(a), strapLevel(b)})
      4'b0000: r = {1'b1, 7'h48};
      4'b0010: r = {1'b1, 7'h49};
      4'b0001: r = {1'b1, 7'h4A};
      4'b0100: r = {1'b1, 7'h4C};
      4'b0110: r = {1'b1, 7'h4D};
      4'b0101: r = {1'b1, 7'h4E};
      4'b1000: r = {1'b1, 7'h4B};
      4'b1001: r = {1'b1, 7'h4F};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2c_reg_port_dp.sv
module i2c_reg_port_dp
  import i2c_reg_port_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_DEFAULT = 8'h8C
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic [1:0]        strapA,
  input  logic [1:0]        strapB,
  input  logic [2*BYTE_W-1:0] resultIn,
  input  logic              staleFlag,
  output logic [BYTE_W-1:0] rxNext,
  output logic [ADDR_W-1:0] addrOwn,
  output logic              addrValid,
  output logic [BYTE_W-1:0] txPreview,
  output logic [BYTE_W-1:0] txByte,
  output logic [BYTE_W-1:0] cfgOut,
  output logic              cfgReadPulse,
  output logic              swResetStb
);

  logic [BYTE_W-2:0] rxShift;
  logic [3:0]        strapLat;
  logic [BYTE_W-1:0] snapLow;
  logic [ADDR_W:0]   decoded;

  assign rxNext    = {rxShift, sdaBit};
  assign decoded   = strapDecode(strapLat[3:2], strapLat[1:0]);
  assign addrValid = decoded[ADDR_W];
  assign addrOwn   = decoded[ADDR_W-1:0];

  always_comb begin
    case (strobe.rdSel)
      2'd0:    txPreview = resultIn[2*BYTE_W-1:BYTE_W];
      2'd1:    txPreview = snapLow;
      2'd2:    txPreview = {staleFlag, cfgOut[BYTE_W-2:0]};
      default: txPreview = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift      <= '0;
      strapLat     <= {strapA, strapB};
      snapLow      <= '0;
      txByte       <= '1;
      cfgOut       <= CFG_DEFAULT;
      cfgReadPulse <= 1'b0;
      swResetStb   <= 1'b0;
    end else begin
      cfgReadPulse <= strobe.loadTx && (strobe.rdSel == 2'd2);
      swResetStb   <= strobe.gcReset;
      if (strobe.shiftIn) rxShift <= rxNext[BYTE_W-2:0];
      if (strobe.gcLatch) strapLat <= {strapA, strapB};
      if (strobe.loadTx) txByte <= txPreview;
      if (strobe.gcReset) begin
        cfgOut  <= CFG_DEFAULT;
        snapLow <= '0;
      end else begin
        if (strobe.cfgWrite) cfgOut <= rxNext;
        if (strobe.loadTx && strobe.rdSel == 2'd0) snapLow <= resultIn[BYTE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/i2c_reg_port_ctrl.sv
module i2c_reg_port_ctrl
  import i2c_reg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rxNext,
  input  logic [ADDR_W-1:0] addrOwn,
  input  logic              addrValid,
  input  logic [BYTE_W-1:0] txPreview,
  input  logic [BYTE_W-1:0] txByte,
  output dpStrobe_t         strobe,
  output logic              sdaPullLow,
  output logic              hsMode
);

  ctrlState_e state;
  xferKind_e  kind;
  logic [3:0] bitCnt;
  logic [1:0] rdIdx;
  logic       byteDone;
  logic       gcCmdOk;

  assign byteDone = strobe.shiftIn && (bitCnt == 4'd7);
  assign gcCmdOk  = (rxNext == 8'h04) || (rxNext == 8'h06);

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = sclRise && (state == ST_ADDR || state == ST_RXDATA);
    strobe.rdSel    = rdIdx;
    strobe.loadTx   = sclFall && ((state == ST_ACKEND && kind == K_READ) || state == ST_MNEXT);
    strobe.cfgWrite = byteDone && state == ST_RXDATA && kind == K_WRITE;
    strobe.gcLatch  = byteDone && state == ST_RXDATA && kind == K_GC && gcCmdOk;
    strobe.gcReset  = byteDone && state == ST_RXDATA && kind == K_GC && (rxNext == 8'h06);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kind       <= K_DONE;
      bitCnt     <= '0;
      rdIdx      <= '0;
      sdaPullLow <= 1'b0;
      hsMode     <= 1'b0;
    end else if (stopDet) begin
      state      <= ST_IDLE;
      sdaPullLow <= 1'b0;
      hsMode     <= 1'b0;
    end else if (startDet) begin
      state      <= ST_ADDR;
      bitCnt     <= '0;
      sdaPullLow <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: if (sclRise) begin
          bitCnt <= bitCnt + 4'd1;
          if (bitCnt == 4'd7) begin
            if (rxNext[7:3] == 5'b00001) begin
              hsMode <= 1'b1;
              state  <= ST_IGNORE;
            end else if (rxNext == 8'h00) begin
              kind  <= K_GC;
              state <= ST_ACKDRV;
            end else if (addrValid && rxNext[7:1] == addrOwn) begin
              kind  <= rxNext[0] ? K_READ : K_WRITE;
              rdIdx <= '0;
              state <= ST_ACKDRV;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_RXDATA: if (sclRise) begin
          bitCnt <= bitCnt + 4'd1;
          if (bitCnt == 4'd7) begin
            if (kind == K_WRITE || (kind == K_GC && gcCmdOk)) begin
              kind  <= K_DONE;
              state <= ST_ACKDRV;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ACKDRV: if (sclFall) begin
          sdaPullLow <= 1'b1;
          state      <= ST_ACKEND;
        end
        ST_ACKEND: if (sclFall) begin
          bitCnt <= '0;
          if (kind == K_READ) begin
            sdaPullLow <= !txPreview[7];
            rdIdx      <= (rdIdx == 2'd3) ? rdIdx : rdIdx + 2'd1;
            state      <= ST_TX;
          end else if (kind == K_DONE) begin
            sdaPullLow <= 1'b0;
            state      <= ST_IGNORE;
          end else begin
            sdaPullLow <= 1'b0;
            state      <= ST_RXDATA;
          end
        end
        ST_TX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaPullLow <= 1'b0;
              state      <= ST_MACK;
            end else begin
              sdaPullLow <= !txByte[3'd7 - bitCnt[2:0]];
            end
          end
        end
        ST_MACK: if (sclRise) state <= sdaBit ? ST_IGNORE : ST_MNEXT;
        ST_MNEXT: if (sclFall) begin
          bitCnt     <= '0;
          sdaPullLow <= !txPreview[7];
          rdIdx      <= (rdIdx == 2'd3) ? rdIdx : rdIdx + 2'd1;
          state      <= ST_TX;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_reg_port_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CFG_DEFAULT = 8'h8C
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaPullLow,
  input  logic [1:0]  strapA,
  input  logic [1:0]  strapB,
  input  logic [15:0] resultIn,
  input  logic        staleFlag,
  output logic [7:0]  cfgOut,
  output logic        cfgReadPulse,
  output logic        swResetStb,
  output logic        hsMode
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic startDet, stopDet, sclRise, sclFall;
  dpStrobe_t         strobe;
  logic [BYTE_W-1:0] rxNext, txPreview, txByte;
  logic [ADDR_W-1:0] addrOwn;
  logic              addrValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign startDet = sclS && sclD && sdaD && !sdaS;
  assign stopDet  = sclS && sclD && !sdaD && sdaS;
  assign sclRise  = sclS && !sclD;
  assign sclFall  = !sclS && sclD;

  i2c_reg_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .sdaBit(sdaS), .rxNext(rxNext),
    .addrOwn(addrOwn), .addrValid(addrValid), .txPreview(txPreview),
    .txByte(txByte), .strobe(strobe), .sdaPullLow(sdaPullLow), .hsMode(hsMode)
  );

  i2c_reg_port_dp #(.CFG_DEFAULT(CFG_DEFAULT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaS),
    .strapA(strapA), .strapB(strapB), .resultIn(resultIn), .staleFlag(staleFlag),
    .rxNext(rxNext), .addrOwn(addrOwn), .addrValid(addrValid),
    .txPreview(txPreview), .txByte(txByte), .cfgOut(cfgOut),
    .cfgReadPulse(cfgReadPulse), .swResetStb(swResetStb)
  );

endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk #(
  parameter logic [7:0] CFG_DEFAULT = 8'h8C
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclS,
  input logic       startDet,
  input logic       stopDet,
  input logic       sdaPullLow,
  input logic       hsMode,
  input logic [7:0] cfgOut,
  input logic       cfgReadPulse,
  input logic       swResetStb
);

  p_sda_scl_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) |-> !$past(sclS));

  p_release_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaPullLow);

  p_release_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaPullLow);

  p_hs_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !hsMode);

  p_cfg_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgReadPulse |=> !cfgReadPulse);

  p_gc_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    swResetStb |-> (cfgOut == CFG_DEFAULT));

endmodule

bind i2c_reg_port i2c_reg_port_chk #(.CFG_DEFAULT(CFG_DEFAULT)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startDet(startDet), .stopDet(stopDet),
  .sdaPullLow(sdaPullLow), .hsMode(hsMode), .cfgOut(cfgOut),
  .cfgReadPulse(cfgReadPulse), .swResetStb(swResetStb)
);

// File: tb/i2c_reg_port_tb.sv
module i2c_reg_port_tb;

  localparam int Q = 6;

  // {strapA, strapB, address, expected ack}
  localparam logic [11:0] STRAP_VEC [9] = '{
    {2'b00, 2'b00, 7'h48, 1'b1},
    {2'b00, 2'b10, 7'h49, 1'b1},
    {2'b00, 2'b01, 7'h4A, 1'b1},
    {2'b01, 2'b00, 7'h4C, 1'b1},
    {2'b01, 2'b10, 7'h4D, 1'b1},
    {2'b01, 2'b01, 7'h4E, 1'b1},
    {2'b10, 2'b00, 7'h4B, 1'b1},
    {2'b10, 2'b01, 7'h4F, 1'b1},
    {2'b10, 2'b10, 7'h48, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN;
  logic sclLine, masterSda;
  logic sdaLine;
  logic sdaPullLow;
  logic [1:0] strapA, strapB;
  logic [15:0] resultIn;
  logic staleFlag;
  logic [7:0] cfgOut;
  logic cfgReadPulse, swResetStb, hsMode;

  int total = 0;
  int fails = 0;
  int pulseCnt = 0;
  int swCnt = 0;
  int badEdge = 0;
  logic prevPull = 1'b0;

  always #10 clk = ~clk;
  assign sdaLine = masterSda & ~sdaPullLow;

  i2c_reg_port u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .strapA(strapA), .strapB(strapB),
    .resultIn(resultIn), .staleFlag(staleFlag), .cfgOut(cfgOut),
    .cfgReadPulse(cfgReadPulse), .swResetStb(swResetStb), .hsMode(hsMode)
  );

  always @(negedge clk) begin
    if (cfgReadPulse) pulseCnt++;
    if (swResetStb) swCnt++;
    if (sclLine && sdaPullLow != prevPull) badEdge++;
    prevPull = sdaPullLow;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; w(5); rstN = 1'b1; w(5);
  endtask

  task automatic i2cStart();
    masterSda = 1'b1; w(Q); sclLine = 1'b1; w(Q);
    masterSda = 1'b0; w(Q); sclLine = 1'b0; w(Q);
  endtask

  task automatic i2cStop();
    masterSda = 1'b0; w(Q); sclLine = 1'b1; w(Q); masterSda = 1'b1; w(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      masterSda = b[i]; w(Q); sclLine = 1'b1; w(2*Q); sclLine = 1'b0; w(Q);
    end
    masterSda = 1'b1; w(Q); sclLine = 1'b1; w(Q);
    ack = !sdaLine;
    w(Q); sclLine = 1'b0; w(Q);
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b);
    masterSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); sclLine = 1'b1; w(Q); b[i] = sdaLine; w(Q); sclLine = 1'b0;
    end
    w(Q); masterSda = !mAck; w(Q); sclLine = 1'b1; w(2*Q); sclLine = 1'b0; w(Q);
    masterSda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int base;
    masterSda = 1'b1; sclLine = 1'b1; rstN = 1'b0;
    strapA = 2'b00; strapB = 2'b00; resultIn = 16'h0; staleFlag = 1'b0;

    // R1: strap table walk
    for (int r = 0; r < 9; r++) begin
      strapA = STRAP_VEC[r][11:10];
      strapB = STRAP_VEC[r][9:8];
      doReset();
      i2cStart(); sendByte({STRAP_VEC[r][7:1], 1'b0}, ack); i2cStop();
      check(16'(ack), 16'(STRAP_VEC[r][0]), $sformatf("R1 strap row %0d ack", r));
    end

    // R11: reset state
    strapA = 2'b00; strapB = 2'b00;
    doReset();
    check(16'(cfgOut), 16'h008C, "R11 cfg default");
    check(16'(hsMode), 16'h0, "R11 hsMode");
    check(16'(sdaPullLow), 16'h0, "R11 pull released");

    // R2: strap change without latch event has no effect
    strapA = 2'b01; strapB = 2'b01;
    i2cStart(); sendByte(8'h90, ack); i2cStop();
    check(16'(ack), 16'h1, "R2 old address still acked");
    i2cStart(); sendByte(8'h9C, ack); i2cStop();
    check(16'(ack), 16'h0, "R2 new address not yet acked");

    // R6: single-byte write
    i2cStart(); sendByte(8'h90, ack);
    sendByte(8'h35, ack); check(16'(ack), 16'h1, "R6 first data acked");
    sendByte(8'hAA, ack); check(16'(ack), 16'h0, "R6 second data not acked");
    i2cStop();
    check(16'(cfgOut), 16'h0035, "R6 cfg holds first byte only");

    // R5, R10: full read burst
    resultIn = 16'h1234; staleFlag = 1'b1; base = pulseCnt;
    i2cStart(); sendByte(8'h91, ack); check(16'(ack), 16'h1, "R5 read address acked");
    readByte(1'b1, b); check(16'(b), 16'h0012, "R5 result high");
    resultIn = 16'h5678;
    readByte(1'b1, b); check(16'(b), 16'h0034, "R5 result low from capture");
    readByte(1'b1, b); check(16'(b), 16'h00B5, "R5 cfg byte with flag");
    readByte(1'b0, b); check(16'(b), 16'h00FF, "R5 pad byte");
    check(16'(sdaPullLow), 16'h0, "R9 released after master NACK");
    i2cStop();
    check(16'(pulseCnt - base), 16'h1, "R10 one cfg read pulse");

    // R5, R9, R8: short read then repeated START
    i2cStart(); sendByte(8'h91, ack);
    readByte(1'b0, b); check(16'(b), 16'h0056, "R5 short read high byte");
    w(2*Q); check(16'(sdaPullLow), 16'h0, "R9 idle after NACK");
    i2cStart(); sendByte(8'h90, ack); check(16'(ack), 16'h1, "R8 repeated START address");
    sendByte(8'h21, ack); i2cStop();
    check(16'(cfgOut), 16'h0021, "R8 write after repeated START");

    // R9: mismatch, then R8 restart
    i2cStart(); sendByte(8'hA0, ack); check(16'(ack), 16'h0, "R9 mismatch not acked");
    sendByte(8'h00, ack); check(16'(ack), 16'h0, "R9 silent after mismatch");
    i2cStart(); sendByte(8'h90, ack); check(16'(ack), 16'h1, "R8 restart after mismatch");
    i2cStop();

    // R3: broadcast 04h re-latch only
    base = swCnt;
    i2cStart(); sendByte(8'h00, ack); check(16'(ack), 16'h1, "R3 broadcast acked");
    sendByte(8'h04, ack); check(16'(ack), 16'h1, "R3 cmd 04 acked"); i2cStop();
    check(16'(cfgOut), 16'h0021, "R3 cmd 04 keeps cfg");
    check(16'(swCnt - base), 16'h0, "R3 cmd 04 no reset pulse");
    i2cStart(); sendByte(8'h9C, ack); check(16'(ack), 16'h1, "R3 new straps after 04");
    sendByte(8'h55, ack); i2cStop();
    check(16'(cfgOut), 16'h0055, "R6 write at new address");

    // R3: broadcast 06h re-latch and reset
    strapA = 2'b00; strapB = 2'b01;
    i2cStart(); sendByte(8'h00, ack);
    sendByte(8'h06, ack); check(16'(ack), 16'h1, "R3 cmd 06 acked"); i2cStop();
    check(16'(cfgOut), 16'h008C, "R3 cfg back to default");
    check(16'(swCnt - base), 16'h1, "R3 reset pulse");
    i2cStart(); sendByte(8'h94, ack); check(16'(ack), 16'h1, "R3 straps latched by 06"); i2cStop();
    i2cStart(); sendByte(8'h01, ack); check(16'(ack), 16'h0, "R3 broadcast read not acked"); i2cStop();

    // R4: high-speed master code
    i2cStart(); sendByte(8'h0B, ack); check(16'(ack), 16'h0, "R4 master code not acked");
    check(16'(hsMode), 16'h1, "R4 hsMode set");
    i2cStart(); sendByte(8'h94, ack); check(16'(ack), 16'h1, "R4 address in hs mode");
    check(16'(hsMode), 16'h1, "R4 hsMode held over repeated START");
    i2cStop(); w(4);
    check(16'(hsMode), 16'h0, "R4 hsMode cleared by STOP");

    // R7: no data-line change from slave while clock high
    check(16'(badEdge), 16'h0, "R7 pull changes only with clock low");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule